// File: doc/BRIEF.md
# Single-Shot Regulator Write Engine

This block is a minimal I2C master that a power-management controller uses to push one register write into an external voltage regulator. Software loads a packed command word holding the 7-bit target address, an 8-bit register index and an 8-bit data value, together with a go flag. The engine then runs one write frame on the two-wire bus and drops the go flag once the bus is back to idle. Software learns of completion by polling that flag.

The frame is START, the address byte with the write direction bit (0) in its last position, the register index byte, the data byte and STOP. Each byte is followed by an acknowledge slot. If the target does not acknowledge, the engine sends STOP straight after that slot and raises a sticky error flag. A clock configuration word sets the SCL low and high durations in system clocks. Each duration carries a fixed hardware extension on top of the programmed count. A mode word stores a filter enable and a two-bit master code, but it never lets high-speed signalling be enabled. Both bus lines are open-drain: an output-enable of 1 pulls the line low.

Top module: `pmic_i2c_writer`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0, the go flag (cmd_rdata bit 24) and ack_err are 0, cfg_rdata holds the default counts (high count 3 in bits 7:0, low count 5 in bits 15:8, value 16'h0503), and mode_rdata is 0.
- R2: A command write while idle stores the target address from bits 6:0, the register index from bits 15:8 and the data value from bits 23:16. These read back at the same positions of cmd_rdata. When bit 24 of the written word is 1, a frame starts and cmd_rdata bit 24 reads 1.
- R3: The frame carries, MSB first, the byte {target address, 0}, then the register index, then the data value. Each byte is followed by a ninth SCL pulse in which the engine releases SDA.
- R4: Every SCL low time lasts (bits 15:8 of the clock word) + 7 clocks. Every SCL high time inside the frame lasts (bits 7:0) + 5 clocks.
- R5: Each frame contains exactly one START (SDA falls while SCL is high), at its beginning, and exactly one STOP (SDA rises while SCL is high), at its end. Otherwise SDA changes only while SCL is low.
- R6: The go flag reads 0 only after the STOP, and at that point both lines are released.
- R7: A NACK (SDA high in an acknowledge slot) at any byte ends the frame with STOP after that slot. No further bytes are sent, the go flag clears and ack_err becomes 1.
- R8: ack_err stays 1 until the next launching command write, which clears it.
- R9: A command write while the go flag is 1 changes neither the stored fields nor the frame on the bus, and it starts no second frame.
- R10: A clock word write stores the high count in bits 7:0 and the low count in bits 15:8, and these read back on cfg_rdata.
- R11: A mode write keeps bit 6 (filter enable) and bits 1:0 (master code). Bit 3 (high-speed enable) always reads 0, and so do the other bits.
- R12: A command write with bit 24 at 0 updates the stored fields but leaves both bus lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_en | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: address 6:0, register 15:8, data 23:16, go 24 |
| cmd_rdata | output | 32 | Command word readback; bit 24 is the go/busy flag |
| cfg_wr_en | input | 1 | Clock word write strobe |
| cfg_wdata | input | 16 | High count 7:0, low count 15:8 |
| cfg_rdata | output | 16 | Clock word readback |
| mode_wr_en | input | 1 | Mode word write strobe |
| mode_wdata | input | 8 | Filter enable 6, high-speed enable 3, master code 1:0 |
| mode_rdata | output | 8 | Mode word readback (bit 3 always 0) |
| ack_err | output | 1 | Sticky missing-acknowledge flag |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The hardest cases to reach from the ports are a missing acknowledge on the register or data byte and a command write that lands in the middle of a frame. The bench models the target on the wired-AND SDA line. It pulls SDA low in each acknowledge slot according to a per-byte plan, so it can refuse any chosen byte. It also decodes START, STOP, bytes and SCL phase widths from the line levels. For the mid-frame write, the bench waits a fixed number of cycles after launch and writes a different command with the go bit set. It then checks that the decoded frame carries only the first command's bytes and contains a single START.

// File: rtl/i2c_wr_pkg.sv
// Shared constants and types for the regulator write engine.
// Assumes the command, clock and mode word layouts listed in the brief.
package i2c_wr_pkg;
    localparam int TGT_LSB      = 0;
    localparam int TGT_W        = 7;
    localparam int REG_LSB      = 8;
    localparam int DAT_LSB      = 16;
    localparam int GO_BIT       = 24;
    localparam int HI_EXTRA     = 5;
    localparam int LO_EXTRA     = 7;
    localparam int MODE_FLT_BIT = 6;
    localparam int MODE_HS_BIT  = 3;
    localparam int ACK_SLOT     = 8;
    localparam int FRAME_BYTES  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_STOP_HI
    } wr_state_t;
endpackage

// File: rtl/i2c_wr_regs.sv
// Software-visible storage: command word with self-clearing go flag,
// clock word, mode word and sticky NACK flag.
// Assumes frame_done pulses for one cycle only while busy is 1.
module i2c_wr_regs
    import i2c_wr_pkg::*;
#(
    parameter int   CNT_W  = 8,
    parameter logic [CNT_W-1:0] DEF_HI = 8'd3,
    parameter logic [CNT_W-1:0] DEF_LO = 8'd5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_en,
    input  logic [31:0]      cmd_wdata,
    input  logic             cfg_wr_en,
    input  logic [2*CNT_W-1:0] cfg_wdata,
    input  logic             mode_wr_en,
    input  logic [7:0]       mode_wdata,
    input  logic             frame_done,
    input  logic             frame_nack,
    output logic             launch,
    output logic             busy,
    output logic [TGT_W-1:0] tgt_addr,
    output logic [7:0]       reg_addr,
    output logic [7:0]       data_byte,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt,
    output logic [7:0]       mode_q,
    output logic             ack_err
);
    logic [7:0] mode_next;
    logic       unused_bits;

    // Writes count only while no frame is running.
    assign launch = cmd_wr_en && !busy && cmd_wdata[GO_BIT];

    // Keep the filter enable and master code; high-speed enable is forced off.
    always_comb begin
        mode_next               = '0;
        mode_next[MODE_FLT_BIT] = mode_wdata[MODE_FLT_BIT];
        mode_next[1:0]          = mode_wdata[1:0];
    end

    assign unused_bits = ^{cmd_wdata[31:GO_BIT+1], cmd_wdata[REG_LSB-1],
                           mode_wdata[7], mode_wdata[5:2]};

    // Command fields and go flag; go clears when the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr  <= '0;
            reg_addr  <= '0;
            data_byte <= '0;
            busy      <= 1'b0;
        end else if (cmd_wr_en && !busy) begin
            tgt_addr  <= cmd_wdata[TGT_LSB +: TGT_W];
            reg_addr  <= cmd_wdata[REG_LSB +: 8];
            data_byte <= cmd_wdata[DAT_LSB +: 8];
            busy      <= cmd_wdata[GO_BIT];
        end else if (frame_done) begin
            busy      <= 1'b0;
        end
    end

    // Sticky NACK flag, cleared by the next launch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_err <= 1'b0;
        else if (launch)
            ack_err <= 1'b0;
        else if (frame_done && frame_nack)
            ack_err <= 1'b1;
    end

    // Clock word: high count in the low half, low count in the upper half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= DEF_HI;
            lo_cnt <= DEF_LO;
        end else if (cfg_wr_en) begin
            hi_cnt <= cfg_wdata[CNT_W-1:0];
            lo_cnt <= cfg_wdata[2*CNT_W-1:CNT_W];
        end
    end

    // Mode word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_wr_en)
            mode_q <= mode_next;
    end
endmodule

// File: rtl/i2c_phase_timer.sv
// Counts system clocks inside one SCL half-period.
// phase_end marks the last clock of the phase; drive_tick marks the
// second clock, where SDA may be changed. Assumes phase_len >= 3.
module i2c_phase_timer #(
    parameter int PH_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PH_W-1:0] phase_len,
    output logic            phase_end,
    output logic            drive_tick
);
    logic [PH_W-1:0] cnt;

    assign phase_end  = run && (cnt == phase_len - 1'b1);
    assign drive_tick = run && (cnt == PH_W'(1));

    // Restart at every phase boundary and hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || phase_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_wr_sequencer.sv
// Walks one write frame: START, the bytes with their acknowledge slots,
// then STOP. SCL and SDA outputs are registered open-drain enables.
// Assumes the phase timer supplies phase_end and drive_tick per phase.
module i2c_wr_sequencer
    import i2c_wr_pkg::*;
#(
    parameter int NBYTES = FRAME_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch,
    input  logic [NBYTES-1:0][7:0] frame_bytes,
    input  logic                   sda_in,
    input  logic                   phase_end,
    input  logic                   drive_tick,
    output logic                   run,
    output logic                   high_phase,
    output logic                   scl_oe,
    output logic                   sda_oe,
    output logic                   frame_done,
    output logic                   frame_nack
);
    localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    wr_state_t         state;
    logic [BIDX_W-1:0] byte_idx;
    logic [3:0]        bit_idx;
    logic              nack_q;
    logic [7:0]        cur_byte;
    logic              cur_bit;
    logic              last_byte;
    logic              in_ack;

    assign cur_byte   = frame_bytes[byte_idx];
    assign cur_bit    = cur_byte[~bit_idx[2:0]];
    assign last_byte  = (byte_idx == BIDX_W'(NBYTES - 1));
    assign in_ack     = (bit_idx == 4'(ACK_SLOT));
    assign run        = (state != ST_IDLE);
    assign high_phase = (state == ST_START) || (state == ST_BIT_HI) ||
                        (state == ST_STOP_HI);
    assign frame_done = (state == ST_STOP_HI) && phase_end;
    assign frame_nack = nack_q;

    // Frame state, bit and byte position, and the line enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= '0;
            nack_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state    <= ST_START;
                        sda_oe   <= 1'b1;
                        byte_idx <= '0;
                        bit_idx  <= '0;
                        nack_q   <= 1'b0;
                    end
                end
                ST_START: begin
                    if (phase_end) begin
                        state  <= ST_BIT_LO;
                        scl_oe <= 1'b1;
                    end
                end
                ST_BIT_LO: begin
                    if (drive_tick)
                        sda_oe <= in_ack ? 1'b0 : !cur_bit;
                    if (phase_end) begin
                        state  <= ST_BIT_HI;
                        scl_oe <= 1'b0;
                    end
                end
                ST_BIT_HI: begin
                    if (phase_end) begin
                        scl_oe <= 1'b1;
                        if (in_ack) begin
                            bit_idx <= '0;
                            if (sda_in || last_byte) begin
                                nack_q <= sda_in;
                                state  <= ST_STOP_LO;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                                state    <= ST_BIT_LO;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= ST_BIT_LO;
                        end
                    end
                end
                ST_STOP_LO: begin
                    if (drive_tick)
                        sda_oe <= 1'b1;
                    if (phase_end) begin
                        state  <= ST_STOP_HI;
                        scl_oe <= 1'b0;
                    end
                end
                ST_STOP_HI: begin
                    if (phase_end) begin
                        state  <= ST_IDLE;
                        sda_oe <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pmic_i2c_writer.sv
// Top of the regulator write engine: register storage, phase timer and
// frame sequencer. Phase lengths add the fixed hardware extensions to
// the programmed counts. Assumes open-drain pads outside the block.
module pmic_i2c_writer
    import i2c_wr_pkg::*;
#(
    parameter int   CNT_W  = 8,
    parameter logic [CNT_W-1:0] DEF_HI = 8'd3,
    parameter logic [CNT_W-1:0] DEF_LO = 8'd5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr_en,
    input  logic [31:0]          cmd_wdata,
    output logic [31:0]          cmd_rdata,
    input  logic                 cfg_wr_en,
    input  logic [2*CNT_W-1:0]   cfg_wdata,
    output logic [2*CNT_W-1:0]   cfg_rdata,
    input  logic                 mode_wr_en,
    input  logic [7:0]           mode_wdata,
    output logic [7:0]           mode_rdata,
    output logic                 ack_err,
    output logic                 scl_oe,
    output logic                 sda_oe,
    input  logic                 sda_in
);
    localparam int PH_W = CNT_W + 1;

    logic                         launch, busy;
    logic [TGT_W-1:0]             tgt_addr;
    logic [7:0]                   reg_addr, data_byte;
    logic [CNT_W-1:0]             hi_cnt, lo_cnt;
    logic                         frame_done, frame_nack;
    logic                         run, high_phase, phase_end, drive_tick;
    logic [PH_W-1:0]              phase_len;
    logic [FRAME_BYTES-1:0][7:0]  frame_bytes;

    i2c_wr_regs #(.CNT_W(CNT_W), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_en  (cmd_wr_en),
        .cmd_wdata  (cmd_wdata),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wdata  (cfg_wdata),
        .mode_wr_en (mode_wr_en),
        .mode_wdata (mode_wdata),
        .frame_done (frame_done),
        .frame_nack (frame_nack),
        .launch     (launch),
        .busy       (busy),
        .tgt_addr   (tgt_addr),
        .reg_addr   (reg_addr),
        .data_byte  (data_byte),
        .hi_cnt     (hi_cnt),
        .lo_cnt     (lo_cnt),
        .mode_q     (mode_rdata),
        .ack_err    (ack_err)
    );

    // Bytes in transmit order; byte 0 carries the write direction bit.
    assign frame_bytes[0] = {tgt_addr, 1'b0};
    assign frame_bytes[1] = reg_addr;
    assign frame_bytes[2] = data_byte;

    // Phase length: programmed count plus the fixed extension.
    assign phase_len = high_phase ? (PH_W'(hi_cnt) + PH_W'(HI_EXTRA))
                                  : (PH_W'(lo_cnt) + PH_W'(LO_EXTRA));

    i2c_phase_timer #(.PH_W(PH_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .phase_len  (phase_len),
        .phase_end  (phase_end),
        .drive_tick (drive_tick)
    );

    i2c_wr_sequencer #(.NBYTES(FRAME_BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .frame_bytes (frame_bytes),
        .sda_in      (sda_in),
        .phase_end   (phase_end),
        .drive_tick  (drive_tick),
        .run         (run),
        .high_phase  (high_phase),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .frame_done  (frame_done),
        .frame_nack  (frame_nack)
    );

    assign cmd_rdata = {7'b0, busy, data_byte, reg_addr, 1'b0, tgt_addr};
    assign cfg_rdata = {lo_cnt, hi_cnt};
endmodule

// File: rtl/i2c_wr_checker.sv
// Protocol and register checks for the regulator write engine, bound
// to the top. Observes only the top's ports.
module i2c_wr_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             busy,
    input logic             ack_err,
    input logic [23:0]      cmd_fields,
    input logic [CNT_W-1:0] lo_cnt
);
    logic [15:0] low_run;

    // Length of the current SCL low stretch in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (scl_oe)
            low_run <= low_run + 1'b1;
        else
            low_run <= '0;
    end

    p_go_starts_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sda_oe && !scl_oe));

    p_start_only_on_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |-> $rose(busy));

    p_stop_ends_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe && $past(!scl_oe)) |-> $fell(busy));

    p_bus_free_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!scl_oe && !sda_oe));

    p_busy_locks_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_fields));

    p_err_at_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_err) |-> $fell(busy));

    p_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> (low_run == 16'(lo_cnt) + 16'd7));
endmodule

bind pmic_i2c_writer i2c_wr_checker #(.CNT_W(CNT_W)) u_wr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .busy       (cmd_rdata[24]),
    .ack_err    (ack_err),
    .cmd_fields (cmd_rdata[23:0]),
    .lo_cnt     (cfg_rdata[2*CNT_W-1:CNT_W])
);

// File: tb/test_pmic_i2c_writer.sv
// Directed bench for the regulator write engine with a wired-AND target model.
module test_pmic_i2c_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        mode_wr_en = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic [7:0]  mode_rdata;
    logic        ack_err, scl_oe, sda_oe, sda_in;

    int n_checks = 0;
    int n_fail   = 0;

    // Target / monitor state
    logic pull = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int   run_len = 1;
    bit   had_low = 0;
    int   starts = 0, stops = 0, nbytes = 0, bitcnt = 0, width_err = 0;
    logic [7:0] shreg = '0;
    logic [7:0] got [0:7];
    bit   ack_plan [0:2];
    int   lo_exp = 12, hi_exp = 8;

    always #2 clk = ~clk;

    assign sda_in = ~sda_oe & ~pull;

    pmic_i2c_writer i_pmic_i2c_writer (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_en(cmd_wr_en), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mode_wr_en(mode_wr_en), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .ack_err(ack_err), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    // Bus monitor and target model, sampled away from the active edge.
    always @(negedge clk) begin
        logic cs, cd;
        cs = ~scl_oe;
        cd = ~sda_oe & ~pull;
        if (cs && prev_scl && prev_sda && !cd) begin
            starts++; bitcnt = 0; nbytes = 0; had_low = 0;
        end
        if (cs && prev_scl && !prev_sda && cd)
            stops++;
        if (cs && !prev_scl) begin
            if (run_len != lo_exp) width_err++;
            had_low = 1;
            if (bitcnt < 8) shreg = {shreg[6:0], cd};
            bitcnt++;
            if (bitcnt == 9) begin
                if (nbytes < 8) got[nbytes] = shreg;
                nbytes++;
                bitcnt = 0;
            end
        end
        if (!cs && prev_scl) begin
            if (had_low && run_len != hi_exp) width_err++;
            pull = (bitcnt == 8) && (nbytes < 3) && ack_plan[nbytes];
        end
        if (cs != prev_scl) run_len = 1; else run_len++;
        prev_scl = cs;
        prev_sda = ~sda_oe & ~pull;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    task automatic clear_mon();
        starts = 0; stops = 0; nbytes = 0; width_err = 0;
        for (int i = 0; i < 8; i++) got[i] = 8'hxx;
    endtask

    task automatic write_cmd(input logic [31:0] w);
        @(negedge clk); cmd_wr_en = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (cmd_rdata[24] && n < 20000) begin @(negedge clk); n++; end
        chk(!cmd_rdata[24], req, "go flag clears", {31'b0, cmd_rdata[24]}, 0);
        repeat (4) @(negedge clk);
    endtask

    // Launch one frame and check every decoded property of it.
    task automatic run_frame(input logic [6:0] t, input logic [7:0] r,
                             input logic [7:0] d, input int nack_at);
        int exp_n;
        for (int i = 0; i < 3; i++) ack_plan[i] = (i != nack_at);
        clear_mon();
        write_cmd({7'b0, 1'b1, d, r, 1'b0, t});
        chk(cmd_rdata[24:0] == {1'b1, d, r, 1'b0, t}, "R2", "fields and go readback",
            cmd_rdata, {7'b0, 1'b1, d, r, 1'b0, t});
        wait_idle("R6");
        exp_n = (nack_at < 0) ? 3 : nack_at + 1;
        chk(starts == 1 && stops == 1, "R5", "one START and one STOP",
            32'(starts * 16 + stops), 32'h11);
        chk(width_err == 0, "R4", "SCL phase widths", 32'(width_err), 0);
        chk(nbytes == exp_n, (nack_at < 0) ? "R3" : "R7", "bytes on bus",
            32'(nbytes), 32'(exp_n));
        chk(got[0] == {t, 1'b0}, "R3", "address byte", {24'b0, got[0]}, {24'b0, t, 1'b0});
        if (exp_n > 1)
            chk(got[1] == r, "R3", "register byte", {24'b0, got[1]}, {24'b0, r});
        if (exp_n > 2)
            chk(got[2] == d, "R3", "data byte", {24'b0, got[2]}, {24'b0, d});
        chk(ack_err == (nack_at >= 0), "R7", "error flag after frame",
            {31'b0, ack_err}, {31'b0, nack_at >= 0});
        chk(!scl_oe && !sda_oe, "R6", "bus released", {30'b0, scl_oe, sda_oe}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1", "lines released", {30'b0, scl_oe, sda_oe}, 0);
        chk(!cmd_rdata[24] && !ack_err, "R1", "go and error clear",
            {30'b0, cmd_rdata[24], ack_err}, 0);
        chk(cfg_rdata == 16'h0503, "R1", "default clock word", {16'b0, cfg_rdata}, 32'h0503);
        chk(mode_rdata == 8'h00, "R1", "mode after reset", {24'b0, mode_rdata}, 0);
    endtask

    task automatic t_basic();
        run_frame(7'h12, 8'h5A, 8'hC3, -1);
        run_frame(7'h7F, 8'h00, 8'hFF, -1);
    endtask

    task automatic t_cfg();
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = 16'h0902;
        @(negedge clk); cfg_wr_en = 1'b0;
        chk(cfg_rdata == 16'h0902, "R10", "clock word readback", {16'b0, cfg_rdata}, 32'h0902);
        lo_exp = 9 + 7; hi_exp = 2 + 5;
        run_frame(7'h2A, 8'h81, 8'h3C, -1);
    endtask

    task automatic t_nack();
        run_frame(7'h55, 8'h10, 8'h20, 0);
        run_frame(7'h31, 8'hA5, 8'h5A, 1);
        run_frame(7'h0C, 8'hF0, 8'h0F, 2);
        repeat (50) @(negedge clk);
        chk(ack_err, "R8", "error flag sticky while idle", {31'b0, ack_err}, 1);
        for (int i = 0; i < 3; i++) ack_plan[i] = 1;
        clear_mon();
        write_cmd({7'b0, 1'b1, 8'h11, 8'h22, 1'b0, 7'h33});
        chk(!ack_err, "R8", "error flag cleared by launch", {31'b0, ack_err}, 0);
        wait_idle("R6");
    endtask

    task automatic t_busy_write();
        for (int i = 0; i < 3; i++) ack_plan[i] = 1;
        clear_mon();
        write_cmd({7'b0, 1'b1, 8'h96, 8'h69, 1'b0, 7'h4B});
        repeat (30) @(negedge clk);
        write_cmd({7'b0, 1'b1, 8'h01, 8'h02, 1'b0, 7'h03});
        chk(cmd_rdata[24:0] == {1'b1, 8'h96, 8'h69, 1'b0, 7'h4B}, "R9",
            "fields unchanged during frame", cmd_rdata, {7'b0, 1'b1, 8'h96, 8'h69, 1'b0, 7'h4B});
        wait_idle("R6");
        repeat (100) @(negedge clk);
        chk(starts == 1 && nbytes == 3, "R9", "single frame only",
            32'(starts * 16 + nbytes), 32'h13);
        chk(got[1] == 8'h69 && got[2] == 8'h96, "R9", "original bytes sent",
            {16'b0, got[1], got[2]}, 32'h6996);
    endtask

    task automatic t_no_go();
        clear_mon();
        write_cmd({7'b0, 1'b0, 8'hBE, 8'hEF, 1'b0, 7'h5C});
        chk(cmd_rdata == {7'b0, 1'b0, 8'hBE, 8'hEF, 1'b0, 7'h5C}, "R12",
            "fields stored without go", cmd_rdata, {7'b0, 1'b0, 8'hBE, 8'hEF, 1'b0, 7'h5C});
        repeat (100) @(negedge clk);
        chk(starts == 0 && !scl_oe && !sda_oe, "R12", "bus stays idle",
            {30'b0, scl_oe, sda_oe} | 32'(starts), 0);
    endtask

    task automatic t_mode();
        @(negedge clk); mode_wr_en = 1'b1; mode_wdata = 8'hFF;
        @(negedge clk); mode_wr_en = 1'b0;
        chk(mode_rdata == 8'h43, "R11", "mode keeps filter and code", {24'b0, mode_rdata}, 32'h43);
        @(negedge clk); mode_wr_en = 1'b1; mode_wdata = 8'h08;
        @(negedge clk); mode_wr_en = 1'b0;
        chk(mode_rdata == 8'h00, "R11", "high-speed enable stays off", {24'b0, mode_rdata}, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) ack_plan[i] = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_mode();
        t_no_go();
        t_busy_write();
        t_nack();
        t_cfg();
        summary();
        $finish;
    end
endmodule